// File: doc/BRIEF.md
# Lockable System Control Register Bank

This block is a bank of status and control registers for a development board, reached over a plain 32-bit register bus with a 12-bit byte offset. Software uses it to identify the board, drive LEDs, keep scratch flags (one word cleared by reset, one word that survives it), request a board reset, set up the display path and read the memory-card slot state. A free-running tick counter that advances at a fixed 24 MHz rate is also readable, whatever the system clock is.

A 32-bit identification word is fixed at build time, and its board-type field (bits 27:16) picks the variant behaviour. The variant decides whether the reset-control register is writable and which data bit triggers a reset. It also decides the display-control reset value and which of its bits can be written, whether the display mux output is driven, and where the write-protect bit lands in the card status word. The reset-control register can only be written after a magic key has been stored in the lock register.

The bus has no back-pressure. A strobe is accepted in the cycle it is presented. Reads answer with a one-cycle valid pulse in the following cycle, and writes produce no response. Offset bits 1:0 are ignored.

Top module: `sysctl_bank`

## Requirements
- R1: A read strobe (`bus_sel`=1, `bus_we`=0) at a clock edge raises `bus_rvalid` for exactly the next cycle, with `bus_rdata` holding the register value from before that edge. `bus_rvalid` is low in every other cycle, including after writes.
- R2: Offset 0x00 reads the `ID_WORD` parameter, 0x44 reads 1, 0x84 reads `PROC_ID` and 0x88 reads 0xFF000000. Every offset not named in R2 to R12 reads 0, and a write to it changes nothing readable.
- R3: Offset 0x08 is a 32-bit LED word, fully readable and writable, cleared by reset.
- R4: A write to 0x20 of exactly 0x0000A05F stores 0xA05F, which means unlocked. Any other write stores data[15:0] AND 0x7FFF. Reads return the stored 16 bits with bits 31:16 zero, and reset clears the value to 0.
- R5: A write to 0x30 ORs the data into the flag word, and a write to 0x34 clears every flag bit that is 1 in the data. Offset 0x30 reads the flag word, offset 0x34 reads 0, and reset clears the flag word.
- R6: A second flag word has its set address at 0x38 (also its read address) and its clear address at 0x3C. Reset does not change it.
- R7: Offset 0x40 is the reset-level word, cleared by reset. Board types 0x100, 0x178 and 0x182 store a write only while the lock holds 0xA05F. On every other board type it reads 0 and ignores writes.
- R8: An accepted reset-level write raises `rst_req` for one cycle, in the cycle after the write, if data bit 8 is set (type 0x100) or data bit 2 is set (types 0x178 and 0x182). Otherwise `rst_req` stays low.
- R9: The display word at 0x50 resets to 0x1F00, or to 0 on type 0x190. On types 0x100 and 0x140 every bit except 13:8 is writable. On 0x178 and 0x182 only bit 7 is writable. On other types it ignores writes.
- R10: On type 0x100, each write to 0x50 loads data[1:0] into `disp_mux` in the next cycle. `disp_mux` is 0 after reset and keeps its value otherwise, and stays 0 on other types.
- R11: Offset 0x48 reads `card_present` in bit 0 and `card_wprot` in bit 2 on types 0x100 and 0x140, or in bit 1 on other types. Other bits read 0, and writes are ignored.
- R12: Offset 0x5C reads floor(n*TICK_HZ/CLK_HZ), where n is the number of clock edges since reset was released, taken before the read edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset, bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read strobe |
| bus_rdata | output | 32 | Read data |
| card_present | input | 1 | Card-detect level |
| card_wprot | input | 1 | Card write-protect level |
| rst_req | output | 1 | Single-cycle board reset request |
| disp_mux | output | 2 | Display format mux select |

## Verification
The assertions assume that the bus is idle while reset is asserted, that `TICK_HZ` does not exceed `CLK_HZ`, and that every strobe is a single well-formed read or write. The bench drives all inputs on the falling edge and keeps the strobe low during reset. It places idle cycles between accesses, so that each reset pulse and each display-mux update can be seen on its own. Three copies of the block with different board types share one stimulus stream. This exercises each variant rule against the same accesses.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam logic [11:0] OFS_ID   = 12'h000;
  localparam logic [11:0] OFS_LED  = 12'h008;
  localparam logic [11:0] OFS_LOCK = 12'h020;
  localparam logic [11:0] OFS_FSET = 12'h030;
  localparam logic [11:0] OFS_FCLR = 12'h034;
  localparam logic [11:0] OFS_NSET = 12'h038;
  localparam logic [11:0] OFS_NCLR = 12'h03C;
  localparam logic [11:0] OFS_RLVL = 12'h040;
  localparam logic [11:0] OFS_ONE  = 12'h044;
  localparam logic [11:0] OFS_CARD = 12'h048;
  localparam logic [11:0] OFS_DISP = 12'h050;
  localparam logic [11:0] OFS_TICK = 12'h05C;
  localparam logic [11:0] OFS_PIDA = 12'h084;
  localparam logic [11:0] OFS_PIDB = 12'h088;

  localparam logic [15:0] UNLOCK_KEY = 16'hA05F;
  localparam logic [15:0] LOCK_MASK  = 16'h7FFF;

  localparam logic [11:0] BRD_A = 12'h100;
  localparam logic [11:0] BRD_B = 12'h140;
  localparam logic [11:0] BRD_C = 12'h178;
  localparam logic [11:0] BRD_D = 12'h182;
  localparam logic [11:0] BRD_E = 12'h190;

  function automatic bit rlvl_enabled(logic [11:0] b);
    return (b == BRD_A) || (b == BRD_C) || (b == BRD_D);
  endfunction

  function automatic int rlvl_trig_bit(logic [11:0] b);
    return (b == BRD_A) ? 8 : 2;
  endfunction

  function automatic logic [31:0] disp_reset(logic [11:0] b);
    return (b == BRD_E) ? 32'h0 : 32'h0000_1F00;
  endfunction

  function automatic logic [31:0] disp_wmask(logic [11:0] b);
    if ((b == BRD_A) || (b == BRD_B)) return ~32'h0000_3F00;
    if ((b == BRD_C) || (b == BRD_D)) return 32'h0000_0080;
    return 32'h0;
  endfunction

  function automatic bit mux_enabled(logic [11:0] b);
    return b == BRD_A;
  endfunction

  function automatic int wprot_bit(logic [11:0] b);
    return ((b == BRD_A) || (b == BRD_B)) ? 2 : 1;
  endfunction
endpackage

// File: rtl/sysctl_tick.sv
module sysctl_tick
  import sysctl_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 100_000_000,
  parameter int unsigned TICK_HZ = 24_000_000,
  parameter int unsigned CNT_W   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] count
);
  localparam int unsigned ACC_W = $clog2(CLK_HZ) + 2;
  localparam logic [ACC_W-1:0] STEP = ACC_W'(TICK_HZ);
  localparam logic [ACC_W-1:0] WRAP = ACC_W'(CLK_HZ);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_sum;

  always_comb acc_sum = acc_q + STEP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      count <= '0;
    end else if (acc_sum >= WRAP) begin
      acc_q <= acc_sum - WRAP;
      count <= count + CNT_W'(1);
    end else begin
      acc_q <= acc_sum;
    end
  end
endmodule

// File: rtl/sysctl_setclr.sv
module sysctl_setclr #(
  parameter int unsigned W             = 32,
  parameter bit          KEEP_ON_RESET = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] data,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (set_en)      nxt = q | data;
    else if (clr_en) nxt = q & ~data;
  end

  generate
    if (KEEP_ON_RESET) begin : g_keep
      always_ff @(posedge clk) begin
        if (rst_n) q <= nxt;
      end
    end else begin : g_clear
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
      end
    end
  endgenerate
endmodule

// File: rtl/sysctl_lockgate.sv
module sysctl_lockgate
  import sysctl_pkg::*;
#(
  parameter logic [11:0] BOARD = 12'h100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lock_we,
  input  logic        rlvl_we,
  input  logic [31:0] wdata,
  output logic [15:0] lock_q,
  output logic [31:0] level_q,
  output logic        rst_req
);
  localparam bit HAS_RLVL = rlvl_enabled(BOARD);
  localparam int TRIG     = rlvl_trig_bit(BOARD);

  logic unlocked;
  logic accept;

  always_comb begin
    unlocked = (lock_q == UNLOCK_KEY);
    accept   = HAS_RLVL && rlvl_we && unlocked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q  <= '0;
      level_q <= '0;
      rst_req <= 1'b0;
    end else begin
      if (lock_we) begin
        lock_q <= (wdata == {16'h0, UNLOCK_KEY}) ? UNLOCK_KEY : (wdata[15:0] & LOCK_MASK);
      end
      if (accept) level_q <= wdata;
      rst_req <= accept && wdata[TRIG];
    end
  end
endmodule

// File: rtl/sysctl_disp.sv
module sysctl_disp
  import sysctl_pkg::*;
#(
  parameter logic [11:0] BOARD = 12'h100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [31:0] wdata,
  output logic [31:0] disp_q,
  output logic [1:0]  mux_q
);
  localparam logic [31:0] WMASK   = disp_wmask(BOARD);
  localparam logic [31:0] RST_VAL = disp_reset(BOARD);
  localparam bit          HAS_MUX = mux_enabled(BOARD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_q <= RST_VAL;
      mux_q  <= 2'b00;
    end else if (we) begin
      disp_q <= (disp_q & ~WMASK) | (wdata & WMASK);
      if (HAS_MUX) mux_q <= wdata[1:0];
    end
  end
endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank
  import sysctl_pkg::*;
#(
  parameter logic [31:0] ID_WORD = 32'h4100_0000,
  parameter logic [31:0] PROC_ID = 32'h0C00_0000,
  parameter int unsigned CLK_HZ  = 100_000_000,
  parameter int unsigned TICK_HZ = 24_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic        bus_rvalid,
  output logic [31:0] bus_rdata,
  input  logic        card_present,
  input  logic        card_wprot,
  output logic        rst_req,
  output logic [1:0]  disp_mux
);
  localparam logic [11:0] BOARD  = ID_WORD[27:16];
  localparam int          WP_BIT = wprot_bit(BOARD);

  logic [11:0] ofs;
  logic        rd_stb, wr_stb;
  logic [31:0] led_q, flags_q, nv_q, level_q, disp_q, tick_q, card_vec, rd_mux;
  logic [15:0] lock_q;

  always_comb begin
    ofs    = bus_addr & 12'hFFC;
    rd_stb = bus_sel && !bus_we;
    wr_stb = bus_sel && bus_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          led_q <= '0;
    else if (wr_stb && ofs == OFS_LED)   led_q <= bus_wdata;
  end

  sysctl_setclr #(.W(32), .KEEP_ON_RESET(1'b0)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .set_en(wr_stb && ofs == OFS_FSET), .clr_en(wr_stb && ofs == OFS_FCLR),
    .data(bus_wdata), .q(flags_q)
  );

  sysctl_setclr #(.W(32), .KEEP_ON_RESET(1'b1)) u_nvflags (
    .clk(clk), .rst_n(rst_n),
    .set_en(wr_stb && ofs == OFS_NSET), .clr_en(wr_stb && ofs == OFS_NCLR),
    .data(bus_wdata), .q(nv_q)
  );

  sysctl_lockgate #(.BOARD(BOARD)) u_lock (
    .clk(clk), .rst_n(rst_n),
    .lock_we(wr_stb && ofs == OFS_LOCK), .rlvl_we(wr_stb && ofs == OFS_RLVL),
    .wdata(bus_wdata), .lock_q(lock_q), .level_q(level_q), .rst_req(rst_req)
  );

  sysctl_disp #(.BOARD(BOARD)) u_disp (
    .clk(clk), .rst_n(rst_n),
    .we(wr_stb && ofs == OFS_DISP), .wdata(bus_wdata),
    .disp_q(disp_q), .mux_q(disp_mux)
  );

  sysctl_tick #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .CNT_W(32)) u_tick (
    .clk(clk), .rst_n(rst_n), .count(tick_q)
  );

  always_comb begin
    card_vec         = '0;
    card_vec[0]      = card_present;
    card_vec[WP_BIT] = card_wprot;
  end

  always_comb begin
    case (ofs)
      OFS_ID:   rd_mux = ID_WORD;
      OFS_LED:  rd_mux = led_q;
      OFS_LOCK: rd_mux = {16'h0, lock_q};
      OFS_FSET: rd_mux = flags_q;
      OFS_NSET: rd_mux = nv_q;
      OFS_RLVL: rd_mux = level_q;
      OFS_ONE:  rd_mux = 32'h1;
      OFS_CARD: rd_mux = card_vec;
      OFS_DISP: rd_mux = disp_q;
      OFS_TICK: rd_mux = tick_q;
      OFS_PIDA: rd_mux = PROC_ID;
      OFS_PIDB: rd_mux = 32'hFF00_0000;
      default:  rd_mux = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd_stb;
      if (rd_stb) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/sysctl_bank_chk.sv
module sysctl_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_we,
  input logic [11:0] bus_addr,
  input logic        bus_rvalid,
  input logic [31:0] bus_rdata,
  input logic        rst_req,
  input logic [1:0]  disp_mux,
  input logic [15:0] lock_val,
  input logic [31:0] tick_val
);
  logic [11:0] w_ofs;
  always_comb w_ofs = bus_addr & 12'hFFC;

  p_rvalid_follows_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we) |=> bus_rvalid);

  p_rvalid_only_reads_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_we) |=> !bus_rvalid);

  p_one_reads_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rvalid && $past(bus_sel && !bus_we && w_ofs == 12'h044)) |-> (bus_rdata == 32'h1));

  p_lock_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rvalid && $past(bus_sel && !bus_we && w_ofs == 12'h020)) |-> (bus_rdata[31:16] == 16'h0));

  p_reset_pulse_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(bus_sel && bus_we && w_ofs == 12'h040 && lock_val == 16'hA05F));

  p_mux_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_we && w_ofs == 12'h050) |=> $stable(disp_mux));

  p_tick_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_val == $past(tick_val)) || (tick_val == $past(tick_val) + 32'd1));
endmodule

bind sysctl_bank sysctl_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .rst_req(rst_req), .disp_mux(disp_mux),
  .lock_val(lock_q), .tick_val(tick_q)
);

// File: tb/sim_sysctl_bank.sv
`timescale 1ns/1ps
module sim_sysctl_bank;
  localparam int unsigned CLK_HZ  = 100_000_000;
  localparam int unsigned TICK_HZ = 24_000_000;
  localparam logic [31:0] PID     = 32'h0C00_0000;
  localparam logic [31:0] IDW0 = 32'h4100_0000;
  localparam logic [31:0] IDW1 = 32'h0182_0000;
  localparam logic [31:0] IDW2 = 32'h0190_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, we = 1'b0, cp = 1'b0, wp = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        rv [3];
  logic [31:0] rd [3];
  logic        rq [3];
  logic [1:0]  mx [3];

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sysctl_bank #(.ID_WORD(IDW0), .PROC_ID(PID), .CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rvalid(rv[0]), .bus_rdata(rd[0]), .card_present(cp), .card_wprot(wp),
    .rst_req(rq[0]), .disp_mux(mx[0]));
  sysctl_bank #(.ID_WORD(IDW1), .PROC_ID(PID), .CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rvalid(rv[1]), .bus_rdata(rd[1]), .card_present(cp), .card_wprot(wp),
    .rst_req(rq[1]), .disp_mux(mx[1]));
  sysctl_bank #(.ID_WORD(IDW2), .PROC_ID(PID), .CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u2 (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rvalid(rv[2]), .bus_rdata(rd[2]), .card_present(cp), .card_wprot(wp),
    .rst_req(rq[2]), .disp_mux(mx[2]));

  // Behavioural reference state, one slot per instance
  logic [31:0] idw [3] = '{IDW0, IDW1, IDW2};
  logic [11:0] brd [3] = '{12'h100, 12'h182, 12'h190};
  logic [31:0] m_led [3], m_flags [3], m_nv [3], m_lvl [3], m_disp [3], e_rd [3];
  logic [15:0] m_lock [3];
  logic [1:0]  m_mux [3];
  logic        e_rv [3], e_rq [3];
  string       e_tag = "R1";
  longint      edges = 0;

  initial begin
    for (int i = 0; i < 3; i++) begin
      m_led[i] = 0; m_flags[i] = 0; m_nv[i] = 0; m_lvl[i] = 0; m_lock[i] = 0;
      m_disp[i] = (brd[i] == 12'h190) ? 32'h0 : 32'h1F00; m_mux[i] = 0;
      e_rv[i] = 0; e_rq[i] = 0; e_rd[i] = 0;
    end
  end

  function automatic string tag_of(logic [11:0] a);
    case (a & 12'hFFC)
      12'h008: return "R3";
      12'h020: return "R4";
      12'h030, 12'h034: return "R5";
      12'h038, 12'h03C: return "R6";
      12'h040: return "R7";
      12'h048: return "R11";
      12'h050: return "R9";
      12'h05C: return "R12";
      default: return "R2";
    endcase
  endfunction

  function automatic logic [31:0] ref_read(int i, logic [11:0] a);
    logic [31:0] v;
    case (a & 12'hFFC)
      12'h000: return idw[i];
      12'h008: return m_led[i];
      12'h020: return {16'h0, m_lock[i]};
      12'h030: return m_flags[i];
      12'h038: return m_nv[i];
      12'h040: return m_lvl[i];
      12'h044: return 32'h1;
      12'h048: begin
        v = 32'(cp);
        if (brd[i] == 12'h100 || brd[i] == 12'h140) v[2] = wp; else v[1] = wp;
        return v;
      end
      12'h050: return m_disp[i];
      12'h05C: return 32'((edges * longint'(TICK_HZ)) / longint'(CLK_HZ));
      12'h084: return PID;
      12'h088: return 32'hFF00_0000;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        m_led[i] = 0; m_flags[i] = 0; m_lvl[i] = 0; m_lock[i] = 0; m_mux[i] = 0;
        m_disp[i] = (brd[i] == 12'h190) ? 32'h0 : 32'h1F00;
        e_rv[i] = 0; e_rq[i] = 0;
      end
      edges = 0;
    end else begin
      for (int i = 0; i < 3; i++) begin
        e_rv[i] = sel && !we;
        e_rq[i] = 1'b0;
        if (sel && !we) e_rd[i] = ref_read(i, addr);
        if (sel && we) begin
          case (addr & 12'hFFC)
            12'h008: m_led[i] = wdata;
            12'h020: m_lock[i] = (wdata == 32'hA05F) ? 16'hA05F : (wdata[15:0] & 16'h7FFF);
            12'h030: m_flags[i] = m_flags[i] | wdata;
            12'h034: m_flags[i] = m_flags[i] & ~wdata;
            12'h038: m_nv[i] = m_nv[i] | wdata;
            12'h03C: m_nv[i] = m_nv[i] & ~wdata;
            12'h040: if ((brd[i] == 12'h100 || brd[i] == 12'h178 || brd[i] == 12'h182)
                         && m_lock[i] == 16'hA05F) begin
              m_lvl[i] = wdata;
              e_rq[i] = (brd[i] == 12'h100) ? wdata[8] : wdata[2];
            end
            12'h050: begin
              if (brd[i] == 12'h100 || brd[i] == 12'h140)
                m_disp[i] = (m_disp[i] & 32'h3F00) | (wdata & ~32'h3F00);
              else if (brd[i] == 12'h178 || brd[i] == 12'h182)
                m_disp[i] = (m_disp[i] & ~32'h80) | (wdata & 32'h80);
              if (brd[i] == 12'h100) m_mux[i] = wdata[1:0];
            end
            default: ;
          endcase
        end
      end
      if (sel && !we) e_tag = tag_of(addr);
      edges = edges + 1;
    end
  end

  task automatic check(bit ok, string req, int inst, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s u%0d t=%0t actual=0x%08h expected=0x%08h", req, inst, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      for (int i = 0; i < 3; i++) begin
        check(rv[i] == e_rv[i], "R1", i, 32'(rv[i]), 32'(e_rv[i]));
        if (e_rv[i]) check(rd[i] == e_rd[i], e_tag, i, rd[i], e_rd[i]);
        check(rq[i] == e_rq[i], "R8", i, 32'(rq[i]), 32'(e_rq[i]));
        check(mx[i] == m_mux[i], "R10", i, 32'(mx[i]), 32'(m_mux[i]));
      end
    end
  end

  task automatic op(bit w, logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_all();
    logic [11:0] lst [16] = '{12'h000, 12'h004, 12'h008, 12'h020, 12'h030, 12'h034, 12'h038,
                              12'h040, 12'h044, 12'h048, 12'h050, 12'h05C, 12'h084, 12'h088,
                              12'h0A0, 12'hFFC};
    for (int k = 0; k < 16; k++) op(1'b0, lst[k], 32'h0);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    nchk++; nfail++;
    $display("FAIL watchdog expired t=%0t actual=0x%08h expected=0x%08h", $time, 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    op(1'b1, 12'h03C, 32'hFFFF_FFFF);           // R6 known start
    read_all();                                  // R2 R3 R4 R9 reset values
    op(1'b1, 12'h008, 32'hDEAD_BEEF); op(1'b0, 12'h008, 0);          // R3
    op(1'b1, 12'h0A0, 32'h1234_5678); op(1'b1, 12'h004, 32'hFFFF_FFFF);
    op(1'b0, 12'h0A0, 0); op(1'b0, 12'h004, 0); op(1'b0, 12'h0A3, 0); // R2 ignored
    op(1'b1, 12'h030, 32'hF0F0_0001); op(1'b1, 12'h030, 32'h0000_0F00); op(1'b0, 12'h030, 0);
    op(1'b1, 12'h034, 32'hF000_0F01); op(1'b0, 12'h030, 0); op(1'b0, 12'h034, 0); // R5
    op(1'b1, 12'h038, 32'hA5A5_0000); op(1'b0, 12'h038, 0);
    op(1'b1, 12'h03C, 32'h0500_0000); op(1'b0, 12'h038, 0);           // R6
    op(1'b1, 12'h040, 32'h0000_0104); op(1'b0, 12'h040, 0);           // R7 locked
    op(1'b1, 12'h020, 32'h0000_FFFF); op(1'b0, 12'h020, 0);           // R4
    op(1'b1, 12'h020, 32'h0001_A05F); op(1'b0, 12'h020, 0);
    op(1'b1, 12'h020, 32'h0000_A05F); op(1'b0, 12'h020, 0);
    op(1'b1, 12'h040, 32'h0000_0004); op(1'b0, 12'h040, 0);           // R7 R8
    op(1'b1, 12'h040, 32'h0000_0100); op(1'b1, 12'h040, 32'h0000_0104);
    op(1'b0, 12'h040, 0);
    op(1'b1, 12'h020, 32'h0); op(1'b1, 12'h040, 32'hFFFF_FFFF); op(1'b0, 12'h040, 0);
    op(1'b0, 12'h050, 0); op(1'b1, 12'h050, 32'hFFFF_FFFF); op(1'b0, 12'h050, 0); // R9 R10
    op(1'b1, 12'h050, 32'h0000_0002); op(1'b0, 12'h050, 0);
    op(1'b1, 12'h050, 32'h0000_0001); idle(2); op(1'b0, 12'h050, 0);
    for (int c = 0; c < 4; c++) begin                                  // R11
      @(negedge clk); cp = c[0]; wp = c[1];
      op(1'b0, 12'h048, 0); op(1'b1, 12'h048, 32'hFFFF_FFFF); op(1'b0, 12'h048, 0);
    end
    idle(50); op(1'b0, 12'h05C, 0); idle(333); op(1'b0, 12'h05C, 0); // R12
    op(1'b1, 12'h038, 32'h0000_00FF); op(1'b1, 12'h008, 32'h1);
    op(1'b1, 12'h020, 32'h0000_A05F); op(1'b1, 12'h030, 32'h8000_0000);
    @(negedge clk); rst_n = 1'b0; idle(2); rst_n = 1'b1;
    read_all();                                                        // R6 kept, rest cleared
    for (int k = 0; k < 48; k++) begin
      logic [11:0] pick [10] = '{12'h008, 12'h020, 12'h030, 12'h034, 12'h038,
                                 12'h03C, 12'h040, 12'h050, 12'h0B4, 12'h048};
      logic [31:0] d = 32'(k) * 32'h9E37_79B9;
      if (k % 7 == 3) d = 32'h0000_A05F;
      op(1'b1, pick[k % 10], d);
      op(1'b0, pick[(k * 3) % 10], 0);
    end
    read_all();
    idle(3);
    finish_run();
  end
endmodule